// File: doc/BRIEF.md
# User Interrupt Recognition and Delivery

This block sits on the receiving core and separates user interrupts from ordinary ones. Every incoming interrupt vector is compared with the user-notification vector, which software keeps in bits 39:32 of a miscellaneous control register. That 8-bit field reaches this block on its own input. A vector that does not match goes out unchanged on the normal-interrupt output. A vector that matches is not sent to normal dispatch. Instead it starts an atomic fetch-and-clear of the posted-interrupt descriptor. The descriptor's 64-bit pending field comes back on the acknowledge and is ORed into the 64-bit user request register.

Requests are delivered one at a time through a handler-entry pulse that carries the vector number. The highest set vector (63 down to 0) goes first. Delivery happens only while the user interrupt flag is set. Delivery clears the flag, so no second request can enter while the handler runs. A return command or an explicit set command sets the flag again. The pipeline redirect, the stack push and privilege checks are outside the block; the entry pulse and the command inputs stand in for them.

Top module: `user_irq_delivery`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, the flag, the request register, entry_valid_o, norm_valid_o and desc_req_o are all zero.
- R2: An incoming vector equal to notify_vec_i raises desc_req_o on the next clock edge and produces no normal-interrupt output.
- R3: An incoming vector not equal to notify_vec_i appears on norm_valid_o/norm_vec_o one clock edge later, with its value unchanged, and starts no descriptor fetch.
- R4: desc_req_o stays high until desc_ack_i is seen. At the edge where both are high, desc_pend_i is ORed into the request register and desc_req_o falls.
- R5: A matching vector that arrives while a fetch is outstanding causes exactly one more fetch. That fetch is requested two edges after the acknowledge of the current one.
- R6: A delivery, which is an entry_valid_o pulse, happens only at an edge where the flag was set and the request register was non-zero. With the flag clear, requests stay pending.
- R7: The delivered vector is the highest set bit of the request register (bit 63 highest, bit 0 lowest), reported on entry_vec_o.
- R8: At the edge of a delivery, the delivered bit is removed from the request register and the flag is cleared.
- R9: uif_set_i or uiret_i sets the flag at the next edge. uif_clr_i clears it, and wins when given together with a set or return.
- R10: When a delivery and a set or return command fall in the same cycle, the delivery wins and the flag ends up clear.
- R11: entry_valid_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| notify_vec_i | input | 8 | User-notification vector (control register bits 39:32) |
| irq_valid_i | input | 1 | Incoming interrupt strobe |
| irq_vec_i | input | 8 | Incoming interrupt vector |
| norm_valid_o | output | 1 | Non-user interrupt forwarded to normal dispatch |
| norm_vec_o | output | 8 | Forwarded vector |
| desc_req_o | output | 1 | Atomic fetch-and-clear of the descriptor pending field |
| desc_ack_i | input | 1 | Fetch complete |
| desc_pend_i | input | 64 | Pending field read by the fetch |
| uif_set_i | input | 1 | Set-flag command |
| uif_clr_i | input | 1 | Clear-flag command |
| uiret_i | input | 1 | Return-from-handler command (sets flag) |
| entry_valid_o | output | 1 | Handler-entry pulse |
| entry_vec_o | output | 6 | Vector being delivered |
| uif_o | output | 1 | Current user interrupt flag |
| uirr_o | output | 64 | Current user request register |

## Verification
The assertions check on every cycle that each entry pulse follows a cycle with the flag set, that it carries the highest bit of the previous request register, and that it clears both the flag and that bit. They also check that pulses never come back-to-back, that the fetch request holds until acknowledged, that the clear command always wins, and that no matched vector leaks to the normal output. The bench scenarios are needed for full delivery orders across random pending masks, for the single extra fetch after notifications that pile up, for pass-through of vector values, and for the fact that pending requests wait while the flag is clear.

// File: rtl/user_irq_pkg.sv
package user_irq_pkg;
  typedef enum logic {
    FETCH_IDLE = 1'b0,
    FETCH_BUSY = 1'b1
  } fetch_state_e;
endpackage

// File: rtl/uirq_match.sv
module uirq_match #(
  parameter int VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_valid_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic [VEC_W-1:0] notify_vec_i,
  output logic             hit_o,
  output logic             norm_valid_o,
  output logic [VEC_W-1:0] norm_vec_o
);
  logic is_user;

  assign is_user = (irq_vec_i == notify_vec_i);
  assign hit_o   = irq_valid_i && is_user;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      norm_valid_o <= 1'b0;
      norm_vec_o   <= '0;
    end else begin
      norm_valid_o <= irq_valid_i && !is_user;
      if (irq_valid_i && !is_user) norm_vec_o <= irq_vec_i;
    end
  end
endmodule

// File: rtl/uirq_fetch.sv
module uirq_fetch
  import user_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic ack_i,
  output logic req_o,
  output logic merge_o
);
  fetch_state_e state_q;
  logic         again_q;   // notification seen while busy

  assign req_o   = (state_q == FETCH_BUSY);
  assign merge_o = req_o && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FETCH_IDLE;
      again_q <= 1'b0;
    end else begin
      unique case (state_q)
        FETCH_IDLE: begin
          if (hit_i || again_q) state_q <= FETCH_BUSY;
          again_q <= 1'b0;
        end
        FETCH_BUSY: begin
          if (ack_i) state_q <= FETCH_IDLE;
          again_q <= again_q || hit_i;
        end
        default: state_q <= FETCH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio #(
  parameter int NUM_VEC = 64,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic [NUM_VEC-1:0] req_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [NUM_VEC-1:0] mask_o
);
  assign any_o = |req_i;

  // last match wins -> highest index
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
    assign mask_o[g] = any_o && (idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/user_irq_delivery.sv
module user_irq_delivery #(
  parameter int NUM_VEC = 64,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [VEC_W-1:0]   notify_vec_i,
  input  logic               irq_valid_i,
  input  logic [VEC_W-1:0]   irq_vec_i,
  output logic               norm_valid_o,
  output logic [VEC_W-1:0]   norm_vec_o,
  output logic               desc_req_o,
  input  logic               desc_ack_i,
  input  logic [NUM_VEC-1:0] desc_pend_i,
  input  logic               uif_set_i,
  input  logic               uif_clr_i,
  input  logic               uiret_i,
  output logic               entry_valid_o,
  output logic [IDX_W-1:0]   entry_vec_o,
  output logic               uif_o,
  output logic [NUM_VEC-1:0] uirr_o
);
  logic               hit;
  logic               merge;
  logic               any_req;
  logic [IDX_W-1:0]   top_idx;
  logic [NUM_VEC-1:0] top_mask;
  logic               deliver;
  logic [NUM_VEC-1:0] uirr_q;
  logic               uif_q;
  logic               entry_valid_q;
  logic [IDX_W-1:0]   entry_vec_q;

  uirq_match #(.VEC_W(VEC_W)) u_match (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .irq_valid_i  (irq_valid_i),
    .irq_vec_i    (irq_vec_i),
    .notify_vec_i (notify_vec_i),
    .hit_o        (hit),
    .norm_valid_o (norm_valid_o),
    .norm_vec_o   (norm_vec_o)
  );

  uirq_fetch u_fetch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .ack_i   (desc_ack_i),
    .req_o   (desc_req_o),
    .merge_o (merge)
  );

  uirq_prio #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_prio (
    .req_i  (uirr_q),
    .any_o  (any_req),
    .idx_o  (top_idx),
    .mask_o (top_mask)
  );

  assign deliver = uif_q && any_req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uirr_q <= '0;
    end else begin
      uirr_q <= (uirr_q & ~(deliver ? top_mask : '0)) | (merge ? desc_pend_i : '0);
    end
  end

  // delivery beats clear beats set/return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uif_q <= 1'b0;
    end else if (deliver || uif_clr_i) begin
      uif_q <= 1'b0;
    end else if (uif_set_i || uiret_i) begin
      uif_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_valid_q <= 1'b0;
      entry_vec_q   <= '0;
    end else begin
      entry_valid_q <= deliver;
      if (deliver) entry_vec_q <= top_idx;
    end
  end

  assign entry_valid_o = entry_valid_q;
  assign entry_vec_o   = entry_vec_q;
  assign uif_o         = uif_q;
  assign uirr_o        = uirr_q;
endmodule

// File: rtl/uirq_checks.sv
module uirq_checks #(
  parameter int NUM_VEC = 64,
  parameter int VEC_W   = 8,
  parameter int IDX_W   = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [VEC_W-1:0]   notify_vec_i,
  input logic               irq_valid_i,
  input logic [VEC_W-1:0]   irq_vec_i,
  input logic               norm_valid_o,
  input logic [VEC_W-1:0]   norm_vec_o,
  input logic               desc_req_o,
  input logic               desc_ack_i,
  input logic               uif_clr_i,
  input logic               entry_valid_o,
  input logic [IDX_W-1:0]   entry_vec_o,
  input logic               uif_o,
  input logic [NUM_VEC-1:0] uirr_o
);
  assert_match_not_forwarded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_valid_i && irq_vec_i == notify_vec_i) |=> !norm_valid_o);

  assert_forward_not_user_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    norm_valid_o |-> (norm_vec_o != $past(notify_vec_i)));

  assert_fetch_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (desc_req_o && !desc_ack_i) |=> desc_req_o);

  assert_entry_needs_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> $past(uif_o));

  assert_entry_highest_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> (($past(uirr_o) >> entry_vec_o) == NUM_VEC'(1)));

  assert_entry_clears_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> !uif_o);

  assert_entry_clears_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_o && !$past(desc_req_o && desc_ack_i)) |-> (((uirr_o >> entry_vec_o) & NUM_VEC'(1)) == '0));

  assert_clear_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uif_clr_i |=> !uif_o);

  assert_single_entry_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |=> !entry_valid_o);
endmodule

bind user_irq_delivery uirq_checks #(
  .NUM_VEC (NUM_VEC),
  .VEC_W   (VEC_W),
  .IDX_W   (IDX_W)
) u_checks (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .notify_vec_i  (notify_vec_i),
  .irq_valid_i   (irq_valid_i),
  .irq_vec_i     (irq_vec_i),
  .norm_valid_o  (norm_valid_o),
  .norm_vec_o    (norm_vec_o),
  .desc_req_o    (desc_req_o),
  .desc_ack_i    (desc_ack_i),
  .uif_clr_i     (uif_clr_i),
  .entry_valid_o (entry_valid_o),
  .entry_vec_o   (entry_vec_o),
  .uif_o         (uif_o),
  .uirr_o        (uirr_o)
);

// File: tb/user_irq_delivery_test.sv
module user_irq_delivery_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  notify_vec_i = 8'hEC;
  logic        irq_valid_i = 1'b0;
  logic [7:0]  irq_vec_i = '0;
  logic        norm_valid_o;
  logic [7:0]  norm_vec_o;
  logic        desc_req_o;
  logic        desc_ack_i = 1'b0;
  logic [63:0] desc_pend_i = '0;
  logic        uif_set_i = 1'b0;
  logic        uif_clr_i = 1'b0;
  logic        uiret_i = 1'b0;
  logic        entry_valid_o;
  logic [5:0]  entry_vec_o;
  logic        uif_o;
  logic [63:0] uirr_o;

  int errors = 0;
  int checks = 0;
  logic [63:0] m_uirr = '0;

  always #10 clk = ~clk;

  user_irq_delivery uut (
    .clk_i(clk), .rst_ni(rst_ni), .notify_vec_i(notify_vec_i),
    .irq_valid_i(irq_valid_i), .irq_vec_i(irq_vec_i),
    .norm_valid_o(norm_valid_o), .norm_vec_o(norm_vec_o),
    .desc_req_o(desc_req_o), .desc_ack_i(desc_ack_i), .desc_pend_i(desc_pend_i),
    .uif_set_i(uif_set_i), .uif_clr_i(uif_clr_i), .uiret_i(uiret_i),
    .entry_valid_o(entry_valid_o), .entry_vec_o(entry_vec_o),
    .uif_o(uif_o), .uirr_o(uirr_o)
  );

  function automatic int highest(input logic [63:0] m);
    int h = -1;
    for (int i = 0; i < 64; i++) if (m[i]) h = i;
    return h;
  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_irq(input logic [7:0] v);
    logic req_before = desc_req_o;
    irq_valid_i = 1'b1; irq_vec_i = v;
    step();
    irq_valid_i = 1'b0;
    if (v == notify_vec_i) begin
      chk("R2", "desc_req", 64'(desc_req_o), 64'd1);
      chk("R2", "norm_valid", 64'(norm_valid_o), 64'd0);
    end else begin
      chk("R3", "norm_valid", 64'(norm_valid_o), 64'd1);
      chk("R3", "norm_vec", 64'(norm_vec_o), 64'(v));
      chk("R3", "no fetch", 64'(desc_req_o), 64'(req_before));
    end
  endtask

  task automatic ack_fetch(input logic [63:0] mask);
    chk("R4", "req before ack", 64'(desc_req_o), 64'd1);
    desc_ack_i = 1'b1; desc_pend_i = mask;
    step();
    desc_ack_i = 1'b0; desc_pend_i = '0;
    m_uirr |= mask;
    chk("R4", "merged uirr", uirr_o, m_uirr);
  endtask

  task automatic deliver_one(input bit use_set);
    int h = highest(m_uirr);
    if (use_set) uif_set_i = 1'b1; else uiret_i = 1'b1;
    step();
    uif_set_i = 1'b0; uiret_i = 1'b0;
    chk("R9", "flag set", 64'(uif_o), 64'd1);
    step();
    m_uirr[h] = 1'b0;
    chk("R6", "entry pulse", 64'(entry_valid_o), 64'd1);
    chk("R7", "entry vector", 64'(entry_vec_o), 64'(h));
    chk("R8", "flag cleared", 64'(uif_o), 64'd0);
    chk("R8", "bit cleared", uirr_o, m_uirr);
    step();
    chk("R11", "pulse ends", 64'(entry_valid_o), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    step(); step();
    chk("R1", "uif in reset", 64'(uif_o), 64'd0);
    chk("R1", "uirr in reset", uirr_o, 64'd0);
    chk("R1", "entry in reset", 64'(entry_valid_o), 64'd0);
    rst_ni = 1'b1;
    step();
    chk("R1", "req after reset", 64'(desc_req_o), 64'd0);
    chk("R1", "norm after reset", 64'(norm_valid_o), 64'd0);

    // flag commands with nothing pending
    uif_set_i = 1'b1; step(); uif_set_i = 1'b0;
    chk("R9", "set", 64'(uif_o), 64'd1);
    step();
    chk("R6", "no entry when empty", 64'(entry_valid_o), 64'd0);
    uif_clr_i = 1'b1; step(); uif_clr_i = 1'b0;
    chk("R9", "clear", 64'(uif_o), 64'd0);
    uif_set_i = 1'b1; uif_clr_i = 1'b1; step();
    uif_set_i = 1'b0; uif_clr_i = 1'b0;
    chk("R9", "clear wins", 64'(uif_o), 64'd0);

    send_irq(8'h20);
    send_irq(8'hEB);

    // priority order with extreme bits
    send_irq(8'hEC);
    ack_fetch(64'h8000_0000_0000_0021);
    step(); step();
    chk("R6", "waits while flag clear", 64'(entry_valid_o), 64'd0);
    chk("R6", "pending kept", uirr_o, m_uirr);
    deliver_one(1'b0);
    deliver_one(1'b1);
    deliver_one(1'b0);
    chk("R8", "all drained", uirr_o, 64'd0);

    // R5: stacked notification during an outstanding fetch
    send_irq(8'hEC);
    send_irq(8'hEC);
    ack_fetch(64'h0000_0000_0000_0100);
    chk("R5", "req drops after ack", 64'(desc_req_o), 64'd0);
    step();
    chk("R5", "second fetch", 64'(desc_req_o), 64'd1);
    ack_fetch(64'h0000_0400_0000_0000);
    step();
    chk("R5", "no third fetch", 64'(desc_req_o), 64'd0);
    deliver_one(1'b0);
    deliver_one(1'b0);

    // R10: delivery and set in the same cycle
    send_irq(8'hEC);
    ack_fetch(64'h0000_0000_0000_0400);
    uiret_i = 1'b1; step(); uiret_i = 1'b0;
    uif_set_i = 1'b1; step(); uif_set_i = 1'b0;
    m_uirr[10] = 1'b0;
    chk("R10", "entry", 64'(entry_valid_o), 64'd1);
    chk("R10", "flag stays clear", 64'(uif_o), 64'd0);
    step();

    // random rounds
    for (int r = 0; r < 15; r++) begin
      logic [7:0] v = 8'($urandom);
      logic [63:0] m = {$urandom, $urandom} & {$urandom, $urandom};
      if (v == notify_vec_i) v = v + 8'd1;
      send_irq(v);
      m[$urandom % 64] = 1'b1;
      send_irq(notify_vec_i);
      ack_fetch(m);
      while (m_uirr != 0) deliver_one(1'($urandom));
      chk("R7", "round drained", uirr_o, 64'd0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule